// File: doc/BRIEF.md
# Chord-Indexed Square-Wave Tone Generator

This block sits after a step sequencer and turns the chord currently being played into an audible square wave. The sequencer supplies a 5-bit column, one bit per voice, together with a one-cycle pulse on each step boundary. The whole column is read as a single index. Together with a bank bit, it forms a 6-bit address into a 64-entry constant table. Each table entry holds the half-period of the note, counted in ticks of a slow time base. A pulse input flips the bank bit, so the same column can give a note from either the lower or the upper half of the table.

A prescaler divides the system clock (50 MHz by default) down to a 50 kHz tick. A half-period counter advances on each tick. When the count reaches the table value, the output flip-flop toggles. Every step pulse clears both the prescaler and the counter and drives the output low, so each new note starts from a known phase. The current table address is brought out so that a display can show it.

Top module: `tone_note_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `tone_o` is 0 and the bank bit is 0, so `addr_o` equals {0, `column_i`}.
- R2: The prescaler issues one tick every DIV = CLK_HZ / TICK_HZ system clocks and restarts its count on each step pulse. After a step edge, the ticks fall on the DIV-th, 2·DIV-th, ... following edges.
- R3: `addr_o` is {bank, `column_i`}. The bank bit is the most significant bit (bit 5) and the column occupies bits 4..0.
- R4: A one-cycle pulse on `bank_toggle_i` inverts the bank bit at the next clock edge.
- R5: The table entry for a column c with 1 ≤ c ≤ 31 is 16 + 48·(31 − c) ticks in bank 0 and 4 + 12·(31 − c) ticks in bank 1. Column 0 holds 0 in both banks. With a 50 kHz tick, every nonzero entry gives a tone between roughly 17 Hz and 6.25 kHz.
- R6: For a nonzero entry H, `tone_o` first rises H·DIV clocks after the step edge. It then stays high for H·DIV clocks and low for H·DIV clocks.
- R7: A step pulse drives `tone_o` low at that edge and restarts the note timing of R6, including when the pulse arrives in the middle of a high phase.
- R8: While the addressed entry is 0 (column 0), `tone_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | One-cycle pulse at each sequencer step boundary |
| column_i | input | 5 | Active voices of the current step, used as a chord index |
| bank_toggle_i | input | 1 | One-cycle pulse that flips the table bank |
| tone_o | output | 1 | Square-wave note output |
| addr_o | output | 6 | Current table address {bank, column} |

## Verification
The note timing is measured at the output for several columns in both banks. The columns are chosen so that their half-periods differ widely: a wrong table slope, a wrong bank or a wrong prescale ratio each moves the measured rise time and the measured high time by a different amount. A step issued in the middle of a high phase shows whether the counters really restart, since a stale prescaler or a stale half counter shortens the first phase. Column 0 is held for many tick periods in both banks to show that the output stays silent. The bank is also toggled back and forth, and the address MSB is checked each time.

// File: rtl/tone_pkg.sv
package tone_pkg;
   localparam int unsigned COL_W_DEF  = 5;
   localparam int unsigned DATA_W_DEF = 16;

   // Half-period in ticks for one table address; column zero means silence.
   function automatic int unsigned note_half(input int unsigned bank,
                                             input int unsigned col,
                                             input int unsigned col_w);
      int unsigned top_col;
      top_col = (1 << col_w) - 1;
      if (col == 0)
         return 0;
      else if (bank == 0)
         return 16 + 48 * (top_col - col);
      else
         return 4 + 12 * (top_col - col);
   endfunction
endpackage

// File: rtl/tone_tick_div.sv
module tone_tick_div #(
   parameter int unsigned DIV = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   output logic tick_o
);
   localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

   if (DIV < 2) begin : g_bad_div
      $error("tone_tick_div: DIV must be at least 2");
   end

   logic [CW-1:0] pre_q;

   assign tick_o = (pre_q == CW'(DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pre_q <= '0;
      else if (clr_i || tick_o)
         pre_q <= '0;
      else
         pre_q <= pre_q + 1'b1;
   end
endmodule

// File: rtl/tone_note_rom.sv
module tone_note_rom
   import tone_pkg::*;
#(
   parameter int unsigned COL_W  = COL_W_DEF,
   parameter int unsigned DATA_W = DATA_W_DEF
) (
   input  logic [COL_W:0]    addr_i,
   output logic [DATA_W-1:0] half_o
);
   localparam int unsigned ADDR_W = COL_W + 1;
   localparam int unsigned DEPTH  = 1 << ADDR_W;
   localparam int unsigned COLS   = 1 << COL_W;

   if (note_half(0, 1, COL_W) >= (1 << DATA_W)) begin : g_bad_width
      $error("tone_note_rom: DATA_W too narrow for the longest note");
   end

   logic [DATA_W-1:0] table_w [DEPTH];

   for (genvar a = 0; a < DEPTH; a++) begin : g_entry
      assign table_w[a] = DATA_W'(note_half(a / COLS, a % COLS, COL_W));
   end

   assign half_o = table_w[addr_i];
endmodule

// File: rtl/tone_half_period.sv
module tone_half_period #(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              tick_i,
   input  logic [DATA_W-1:0] half_i,
   output logic              tone_o
);
   logic [DATA_W-1:0] cnt_q;
   logic              tone_q;
   logic              reach_w;

   assign reach_w = (cnt_q >= half_i - 1'b1);
   assign tone_o  = tone_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         tone_q <= 1'b0;
      end else if (clr_i) begin
         cnt_q  <= '0;
         tone_q <= 1'b0;
      end else if (tick_i) begin
         if (half_i == '0) begin
            cnt_q  <= '0;
            tone_q <= 1'b0;
         end else if (reach_w) begin
            cnt_q  <= '0;
            tone_q <= ~tone_q;
         end else begin
            cnt_q  <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/tone_note_gen.sv
module tone_note_gen
   import tone_pkg::*;
#(
   parameter int unsigned CLK_HZ  = 50_000_000,
   parameter int unsigned TICK_HZ = 50_000,
   parameter int unsigned COL_W   = COL_W_DEF,
   parameter int unsigned DATA_W  = DATA_W_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   input  logic [COL_W-1:0] column_i,
   input  logic             bank_toggle_i,
   output logic             tone_o,
   output logic [COL_W:0]   addr_o
);
   localparam int unsigned DIV = CLK_HZ / TICK_HZ;

   if (CLK_HZ % TICK_HZ != 0) begin : g_bad_ratio
      $error("tone_note_gen: CLK_HZ must be a multiple of TICK_HZ");
   end

   logic              bank_q;
   logic              tick_w;
   logic [DATA_W-1:0] half_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bank_q <= 1'b0;
      else if (bank_toggle_i)
         bank_q <= ~bank_q;
   end

   assign addr_o = {bank_q, column_i};

   tone_tick_div #(.DIV(DIV)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (step_i),
      .tick_o (tick_w)
   );

   tone_note_rom #(.COL_W(COL_W), .DATA_W(DATA_W)) u_rom (
      .addr_i (addr_o),
      .half_o (half_w)
   );

   tone_half_period #(.DATA_W(DATA_W)) u_half (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (step_i),
      .tick_i (tick_w),
      .half_i (half_w),
      .tone_o (tone_o)
   );
endmodule

// File: rtl/tone_note_gen_chk.sv
module tone_note_gen_chk #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              step_i,
   input logic              bank_toggle_i,
   input logic              tick,
   input logic [DATA_W-1:0] half,
   input logic              tone_o,
   input logic [ADDR_W-1:0] addr_o
);
   assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

   assert_step_restarts_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      step_i |=> !tick);

   assert_bank_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bank_toggle_i |=> (addr_o[ADDR_W-1] != $past(addr_o[ADDR_W-1])));

   assert_bank_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !bank_toggle_i |=> (addr_o[ADDR_W-1] == $past(addr_o[ADDR_W-1])));

   assert_toggle_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !step_i) |=> $stable(tone_o));

   assert_step_silences_R7: assert property (@(posedge clk) disable iff (!rst_n)
      step_i |=> !tone_o);

   assert_zero_entry_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && half == '0) |=> !tone_o);
endmodule

bind tone_note_gen tone_note_gen_chk #(.DATA_W(DATA_W), .ADDR_W(COL_W + 1)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .step_i        (step_i),
   .bank_toggle_i (bank_toggle_i),
   .tick          (tick_w),
   .half          (half_w),
   .tone_o        (tone_o),
   .addr_o        (addr_o)
);

// File: tb/tone_note_gen_tb.sv
`timescale 1ns/1ps
module tone_note_gen_tb;
   localparam int unsigned TB_CLK  = 800;
   localparam int unsigned TB_TICK = 100;
   localparam int unsigned DIV     = TB_CLK / TB_TICK;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       step_i = 1'b0;
   logic [4:0] column_i = '0;
   logic       bank_toggle_i = 1'b0;
   logic       tone_o;
   logic [5:0] addr_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   bit bank_m = 1'b0;

   always #2.5 clk = ~clk;

   tone_note_gen #(.CLK_HZ(TB_CLK), .TICK_HZ(TB_TICK)) u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .step_i        (step_i),
      .column_i      (column_i),
      .bank_toggle_i (bank_toggle_i),
      .tone_o        (tone_o),
      .addr_o        (addr_o)
   );

   function automatic int exp_half(input bit bank, input int col);
      if (col == 0) return 0;
      return bank ? (4 + 12 * (31 - col)) : (16 + 48 * (31 - col));
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic pulse_step(input logic [4:0] col);
      @(negedge clk);
      column_i = col;
      step_i   = 1'b1;
      @(negedge clk);
      step_i   = 1'b0;
   endtask

   task automatic measure(input logic [4:0] col, input string tag);
      int h, n, m;
      h = exp_half(bank_m, col) * DIV;
      pulse_step(col);
      check(tone_o == 1'b0, {tag, " R7 low after step"}, tone_o, 0);
      n = 0;
      while (tone_o == 1'b0 && n < 4 * h + 50) begin
         @(negedge clk);
         n++;
      end
      check(n == h, {tag, " R2 R5 R6 rise delay"}, n, h);
      m = 0;
      while (tone_o == 1'b1 && m < 4 * h + 50) begin
         @(negedge clk);
         m++;
      end
      check(m == h, {tag, " R6 high time"}, m, h);
   endtask

   task automatic toggle_bank();
      @(negedge clk);
      bank_toggle_i = 1'b1;
      @(negedge clk);
      bank_toggle_i = 1'b0;
      bank_m = ~bank_m;
      check(addr_o[5] == bank_m, "R4 bank flip", addr_o[5], bank_m);
   endtask

   task automatic t_reset();
      column_i = 5'd9;
      repeat (3) @(negedge clk);
      check(tone_o == 1'b0, "R1 tone low in reset", tone_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(tone_o == 1'b0, "R1 tone low after reset", tone_o, 0);
      check(addr_o == 6'd9, "R1 R3 address after reset", addr_o, 9);
   endtask

   task automatic t_address();
      @(negedge clk);
      column_i = 5'd22;
      #1;
      check(addr_o == {bank_m, 5'd22}, "R3 address column 22", addr_o, {bank_m, 5'd22});
      column_i = 5'd31;
      #1;
      check(addr_o == {bank_m, 5'd31}, "R3 address column 31", addr_o, {bank_m, 5'd31});
   endtask

   task automatic t_lower();
      measure(5'd31, "lower c31");
      measure(5'd30, "lower c30");
      measure(5'd17, "lower c17");
   endtask

   task automatic t_upper();
      toggle_bank();
      check(addr_o == {1'b1, column_i}, "R3 upper address", addr_o, {1'b1, column_i});
      measure(5'd31, "upper c31");
      measure(5'd25, "upper c25");
      measure(5'd1, "upper c1");
      toggle_bank();
      measure(5'd28, "lower again c28");
   endtask

   task automatic t_silence();
      bit seen;
      for (int b = 0; b < 2; b++) begin
         pulse_step(5'd0);
         seen = 1'b0;
         repeat (40 * DIV) begin
            @(negedge clk);
            if (tone_o) seen = 1'b1;
         end
         check(!seen, "R8 column 0 silent", seen, 0);
         toggle_bank();
      end
   endtask

   task automatic t_restart();
      int h, n;
      h = exp_half(bank_m, 29) * DIV;
      pulse_step(5'd29);
      repeat (h + 3) @(negedge clk);
      check(tone_o == 1'b1, "R6 high mid-note", tone_o, 1);
      pulse_step(5'd29);
      check(tone_o == 1'b0, "R7 step forces low", tone_o, 0);
      n = 0;
      while (tone_o == 1'b0 && n < 4 * h) begin
         @(negedge clk);
         n++;
      end
      check(n == h, "R7 R2 full restart delay", n, h);
   endtask

   initial begin
      t_reset();
      t_address();
      t_lower();
      t_upper();
      t_silence();
      t_restart();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule